// File: doc/BRIEF.md
# Dual External Address Pointer Unit

This unit keeps two 16-bit pointers for external data-memory moves and presents whichever is active on an address output. Software reaches the pointers and a control byte over a byte-wide register bus with an address, a write enable, write data and combinational read data. The core does the decoding and reports only events: a one-cycle strobe for each external data move, a strobe for an explicit pointer step, and a strobe for an explicit pointer swap.

A block copy keeps the source address in one pointer and the destination in the other. With the auto-swap bit set, each external move hands over to the other pointer. With the auto-step bit set, each move advances the pointer it used. Each pointer has its own direction bit, so a copy can run upward through one region and downward through another. After reset every control bit is clear, and the unit acts as a plain single-pointer machine on pointer 0.

All pins are plain control and data signals. There is no data stream here, so no port uses valid/ready handshaking and there is no back-pressure.

Top module: `xptr_bank`

## Requirements
- R1: After reset both pointers read 0000h, the control byte reads 00h and `xaddr` is 0000h.
- R2: Register map, read combinationally on `reg_rdata`: 82h holds pointer 0 bits 7:0 and 83h holds bits 15:8. 84h holds pointer 1 bits 7:0 and 85h holds bits 15:8. 86h is the control byte: bit 0 is the select (0 = pointer 0), bit 2 is the pointer 0 direction, bit 3 is the pointer 1 direction, bit 5 is auto-swap and bit 6 is auto-step. Bits 1, 4 and 7 read 0, and any unmapped address reads 00h.
- R3: `xaddr` always equals the pointer chosen by the select bit.
- R4: A `step_stb` changes only the active pointer, one cycle later. It adds 1 if that pointer's direction bit is 0 and subtracts 1 if it is 1. At most one of `xmove_stb`, `step_stb` and `swap_stb` is high in any cycle.
- R5: Stepping wraps modulo 2^16: FFFFh up gives 0000h, and 0000h down gives FFFFh.
- R6: A `swap_stb` inverts the select bit.
- R7: An `xmove_stb` inverts the select bit when auto-swap is 1 and leaves it unchanged when auto-swap is 0.
- R8: An `xmove_stb` with auto-step set steps the active pointer by the rule of R4. If auto-swap is also set, the pointer stepped is the one that was active during the access, and the select inverts afterwards.
- R9: A register write in the same cycle as a step or a select inversion wins for the written byte. The other byte of a stepped pointer still takes its stepped value.
- R10: Reads have no side effects: repeated reads leave every register and `xaddr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register bus address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| xmove_stb | input | 1 | External data move executed this cycle |
| step_stb | input | 1 | Explicit step of the active pointer |
| swap_stb | input | 1 | Explicit inversion of the select bit |
| xaddr | output | 16 | Active pointer value, used as the external address |

## Verification
A wrong select bit shows at once on `xaddr` as the other pointer's value. A wrong step amount or direction shows on `xaddr` in the cycle after the strobe if the stepped pointer is active, and otherwise on the next read of its bytes. A lost write priority or a missing wrap shows on the first read back of the affected byte. The bench keeps a behavioural model and compares `xaddr` and `reg_rdata` in every cycle, so every such fault is caught within one cycle of the point where it becomes visible.

// File: rtl/xptr_pkg.sv
package xptr_pkg;
  typedef struct packed {
    logic auto_step;
    logic auto_swap;
    logic dir1;
    logic dir0;
    logic sel;
  } xptr_ctrl_t;

  localparam int unsigned SEL_BIT  = 0;
  localparam int unsigned DIR0_BIT = 2;
  localparam int unsigned DIR1_BIT = 3;
  localparam int unsigned SWAP_BIT = 5;
  localparam int unsigned STEP_BIT = 6;
endpackage

// File: rtl/xptr_step.sv
module xptr_step #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] val,
  input  logic         down,
  output logic [W-1:0] nxt
);
  always_comb nxt = down ? (val - W'(1)) : (val + W'(1));
endmodule

// File: rtl/xptr_ctrl.sv
module xptr_ctrl
  import xptr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CTRL_ADDR = 'h86
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              xmove_stb,
  input  logic              swap_stb,
  output xptr_ctrl_t        ctrl,
  output logic [DATA_W-1:0] ctrl_rd
);
  logic wr_hit;
  logic flip;

  always_comb begin
    wr_hit = reg_we && (reg_addr == ADDR_W'(CTRL_ADDR));
    flip   = swap_stb | (xmove_stb & ctrl.auto_swap);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr_hit) begin
      ctrl.sel       <= reg_wdata[SEL_BIT];
      ctrl.dir0      <= reg_wdata[DIR0_BIT];
      ctrl.dir1      <= reg_wdata[DIR1_BIT];
      ctrl.auto_swap <= reg_wdata[SWAP_BIT];
      ctrl.auto_step <= reg_wdata[STEP_BIT];
    end else if (flip) begin
      ctrl.sel <= ~ctrl.sel;
    end
  end

  always_comb begin
    ctrl_rd = '0;
    if (reg_addr == ADDR_W'(CTRL_ADDR)) begin
      ctrl_rd[SEL_BIT]  = ctrl.sel;
      ctrl_rd[DIR0_BIT] = ctrl.dir0;
      ctrl_rd[DIR1_BIT] = ctrl.dir1;
      ctrl_rd[SWAP_BIT] = ctrl.auto_swap;
      ctrl_rd[STEP_BIT] = ctrl.auto_step;
    end
  end

  assert_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_stb && !wr_hit) |=> (ctrl.sel != $past(ctrl.sel)));

  assert_auto_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xmove_stb && ctrl.auto_swap && !wr_hit) |=> (ctrl.sel != $past(ctrl.sel)));

  assert_sel_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!swap_stb && !(xmove_stb && ctrl.auto_swap) && !wr_hit) |=> $stable(ctrl.sel));
endmodule

// File: rtl/xptr_cell.sv
module xptr_cell #(
  parameter int unsigned PTR_W  = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BASE   = 'h82
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              step_en,
  input  logic              step_down,
  output logic [PTR_W-1:0]  ptr,
  output logic [DATA_W-1:0] rd
);
  localparam int unsigned NB = PTR_W / DATA_W;

  logic [PTR_W-1:0] stepped;
  logic [NB-1:0]    byte_hit;

  xptr_step #(.W(PTR_W)) i_step (
    .val  (ptr),
    .down (step_down),
    .nxt  (stepped)
  );

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign byte_hit[b] = reg_we && (reg_addr == ADDR_W'(BASE + b));

    always_ff @(posedge clk) begin
      if (!rst_n)
        ptr[b*DATA_W +: DATA_W] <= '0;
      else if (byte_hit[b])
        ptr[b*DATA_W +: DATA_W] <= reg_wdata;
      else if (step_en)
        ptr[b*DATA_W +: DATA_W] <= stepped[b*DATA_W +: DATA_W];
    end

    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      byte_hit[b] |=> (ptr[b*DATA_W +: DATA_W] == $past(reg_wdata)));
  end

  always_comb begin
    rd = '0;
    for (int b = 0; b < NB; b++)
      if (reg_addr == ADDR_W'(BASE + b)) rd = ptr[b*DATA_W +: DATA_W];
  end

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && byte_hit == '0) |=>
      (ptr == ($past(step_down) ? $past(ptr) + PTR_W'({PTR_W{1'b1}}) : $past(ptr) + PTR_W'(1))));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && byte_hit == '0) |=> $stable(ptr));
endmodule

// File: rtl/xptr_bank.sv
module xptr_bank
  import xptr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PTR_W     = 16,
  parameter int unsigned P0_BASE   = 'h82,
  parameter int unsigned P1_BASE   = 'h84,
  parameter int unsigned CTRL_ADDR = 'h86
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              xmove_stb,
  input  logic              step_stb,
  input  logic              swap_stb,
  output logic [PTR_W-1:0]  xaddr
);
  localparam int unsigned NPTR = 2;

  xptr_ctrl_t        ctrl;
  logic [DATA_W-1:0] ctrl_rd;
  logic              do_step;
  logic [PTR_W-1:0]  ptr_q  [NPTR];
  logic [DATA_W-1:0] ptr_rd [NPTR];

  xptr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .xmove_stb (xmove_stb),
    .swap_stb  (swap_stb),
    .ctrl      (ctrl),
    .ctrl_rd   (ctrl_rd)
  );

  assign do_step = step_stb | (xmove_stb & ctrl.auto_step);

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    xptr_cell #(
      .PTR_W  (PTR_W),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .BASE   ((i == 0) ? P0_BASE : P1_BASE)
    ) i_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .step_en   (do_step && (ctrl.sel == 1'(i))),
      .step_down ((i == 0) ? ctrl.dir0 : ctrl.dir1),
      .ptr       (ptr_q[i]),
      .rd        (ptr_rd[i])
    );
  end

  always_comb begin
    xaddr     = ctrl.sel ? ptr_q[1] : ptr_q[0];
    reg_rdata = ptr_rd[0] | ptr_rd[1] | ctrl_rd;
  end

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xmove_stb, step_stb, swap_stb}));

  assert_read_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && !xmove_stb && !step_stb && !swap_stb) |=> $stable(xaddr));
endmodule

// File: tb/test_xptr_bank.sv
module test_xptr_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       xmove_stb = 1'b0;
  logic       step_stb = 1'b0;
  logic       swap_stb = 1'b0;
  logic [15:0] xaddr;

  int checks = 0;
  int errors = 0;

  // behavioural model state
  int mp[2];
  bit msel, md0, md1, mswap, mstep;

  always #5 clk = ~clk;

  xptr_bank i_xptr_bank (
    .clk, .rst_n, .reg_addr, .reg_we, .reg_wdata, .reg_rdata,
    .xmove_stb, .step_stb, .swap_stb, .xaddr
  );

  function automatic int model_rd(input logic [7:0] a);
    case (a)
      8'h82: return mp[0] & 'hFF;
      8'h83: return (mp[0] >> 8) & 'hFF;
      8'h84: return mp[1] & 'hFF;
      8'h85: return (mp[1] >> 8) & 'hFF;
      8'h86: return {25'd0, mstep, mswap, 1'b0, md1, md0, 1'b0, msel};
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input logic [7:0] a, input logic we,
                     input logic [7:0] wd, input logic xm, input logic st, input logic sw);
    int s;
    bit dir, flip;
    @(negedge clk);
    reg_addr = a; reg_we = we; reg_wdata = wd;
    xmove_stb = xm; step_stb = st; swap_stb = sw;
    #1;
    check(tag, "xaddr", int'(xaddr), mp[msel]);
    check(tag, "rdata", int'(reg_rdata), model_rd(a));
    @(posedge clk);
    s = msel;
    dir = s ? md1 : md0;
    if (st || (xm && mstep))
      mp[s] = dir ? ((mp[s] - 1) & 'hFFFF) : ((mp[s] + 1) & 'hFFFF);
    flip = sw || (xm && mswap);
    if (we) begin
      case (a)
        8'h82: mp[0] = (mp[0] & 'hFF00) | int'(wd);
        8'h83: mp[0] = (mp[0] & 'h00FF) | (int'(wd) << 8);
        8'h84: mp[1] = (mp[1] & 'hFF00) | int'(wd);
        8'h85: mp[1] = (mp[1] & 'h00FF) | (int'(wd) << 8);
        default: ;
      endcase
    end
    if (we && a == 8'h86) begin
      msel = wd[0]; md0 = wd[2]; md1 = wd[3]; mswap = wd[5]; mstep = wd[6];
    end else if (flip) begin
      msel = ~msel;
    end
  endtask

  task automatic wr(input string tag, input logic [7:0] a, input logic [7:0] d);
    cyc(tag, a, 1'b1, d, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic rd(input string tag, input logic [7:0] a);
    cyc(tag, a, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mp[0] = 0; mp[1] = 0;
    msel = 0; md0 = 0; md1 = 0; mswap = 0; mstep = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset values on every address
    for (int a = 8'h80; a < 8'h88; a++) rd("R1", 8'(a));

    // R2: byte mapping, unused control bits, unmapped addresses
    wr("R2", 8'h82, 8'h34); wr("R2", 8'h83, 8'h12);
    wr("R2", 8'h84, 8'h78); wr("R2", 8'h85, 8'h56);
    for (int a = 8'h80; a < 8'h88; a++) rd("R2", 8'(a));
    wr("R2", 8'h86, 8'h92);
    rd("R2", 8'h86);
    wr("R2", 8'h86, 8'h00);

    // R3: select chooses the address source
    wr("R3", 8'h86, 8'h01); rd("R3", 8'h80);
    wr("R3", 8'h86, 8'h00); rd("R3", 8'h80);

    // R4: explicit step, up on pointer 0, down on pointer 1
    wr("R4", 8'h86, 8'h08);
    cyc("R4", 8'h84, 0, 0, 0, 1, 0); rd("R4", 8'h82); rd("R4", 8'h84);
    wr("R4", 8'h86, 8'h09);
    cyc("R4", 8'h82, 0, 0, 0, 1, 0); rd("R4", 8'h84); rd("R4", 8'h82);

    // R5: wrap both ways
    wr("R5", 8'h86, 8'h00);
    wr("R5", 8'h82, 8'hFF); wr("R5", 8'h83, 8'hFF);
    cyc("R5", 8'h83, 0, 0, 0, 1, 0); rd("R5", 8'h83); rd("R5", 8'h82);
    wr("R5", 8'h86, 8'h04);
    cyc("R5", 8'h82, 0, 0, 0, 1, 0); rd("R5", 8'h83); rd("R5", 8'h82);

    // R6: explicit swap
    wr("R6", 8'h86, 8'h00);
    cyc("R6", 8'h86, 0, 0, 0, 0, 1); rd("R6", 8'h86);
    cyc("R6", 8'h86, 0, 0, 0, 0, 1); rd("R6", 8'h86);

    // R7: auto swap on/off
    cyc("R7", 8'h86, 0, 0, 1, 0, 0); rd("R7", 8'h86);
    wr("R7", 8'h86, 8'h20);
    for (int k = 0; k < 4; k++) cyc("R7", 8'h86, 0, 0, 1, 0, 0);
    rd("R7", 8'h86);

    // R8: block copy, source up on pointer 0, destination down on pointer 1
    wr("R8", 8'h82, 8'h00); wr("R8", 8'h83, 8'h10);
    wr("R8", 8'h84, 8'h05); wr("R8", 8'h85, 8'h20);
    wr("R8", 8'h86, 8'h68);
    for (int k = 0; k < 10; k++) cyc("R8", 8'h82, 0, 0, 1, 0, 0);
    for (int a = 8'h82; a < 8'h87; a++) rd("R8", 8'(a));
    wr("R8", 8'h86, 8'h40);
    for (int k = 0; k < 3; k++) cyc("R8", 8'h86, 0, 0, 1, 0, 0);

    // R9: write races a step and a swap
    wr("R9", 8'h86, 8'h00);
    wr("R9", 8'h82, 8'hFF); wr("R9", 8'h83, 8'h01);
    cyc("R9", 8'h82, 1, 8'h55, 0, 1, 0); rd("R9", 8'h82); rd("R9", 8'h83);
    cyc("R9", 8'h86, 1, 8'h00, 0, 0, 1); rd("R9", 8'h86);
    wr("R9", 8'h86, 8'h60);
    cyc("R9", 8'h83, 1, 8'hAA, 1, 0, 0); rd("R9", 8'h83); rd("R9", 8'h82);

    // R10: reads leave everything unchanged
    for (int k = 0; k < 6; k++) rd("R10", 8'(8'h82 + k));
    for (int k = 0; k < 6; k++) rd("R10", 8'(8'h82 + k));

    // mixed traffic against the model
    for (int k = 0; k < 3000; k++) begin
      int r;
      logic we;
      r = $urandom % 6;
      we = (($urandom % 4) == 0);
      cyc("R8", 8'(8'h80 + ($urandom % 8)), we, 8'($urandom),
          r == 0, r == 1, r == 2);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule